// File: doc/BRIEF.md
# BCD Calendar Clock Core

This block keeps wall-clock time and date in packed BCD and advances them by one second each time a sub-second prescaler completes a full count of `subTick` pulses. Seconds, minutes, 24-hour hours, date, month and a two-digit year are kept in BCD. The weekday is a plain binary count from 0 to 6. Month lengths follow the calendar for the years 2000 to 2099, including February 29 in every year that divides by four.

A minute/hour/date alarm, a status register of sticky flags and an interrupt enable register sit beside the time registers in one 8-bit address space. One write port and one combinational read port reach all of them. The active-low interrupt line stays low for as long as an enabled flag is set. Software releases it by writing 0 to that flag.

Writing the seconds register restarts the prescaler. The next second therefore starts one full prescaler period after the write. The alarm has no seconds field, so a match is only tested at the moment the seconds roll over to 00.

Top module: `rtc_core`

## Requirements
- R1: After reset the time reads 2000-01-01 00:00:00 with weekday 0: addresses 0x00-0x03 and 0x06 read 0x00, and 0x04 (date) and 0x05 (month) read 0x01. Status (0x0E) reads 0x01, the enable register (0x10) reads 0x00, and `irqN` is 1.
- R2: Seconds (0x00) advance by one BCD step on every TICKS_PER_SEC-th `subTick` pulse, going from x9 to the next ten (09 to 10).
- R3: Seconds 59 wrap to 00 and carry into minutes. Minutes 59 wrap and carry into hours. Hours 23 wrap to 00, which advances the date and the weekday (0x03, 6 wraps to 0).
- R4: The date wraps after the last day of the month: 30 for months 04, 06, 09 and 11; 29 for month 02 when the BCD year divides by 4; 28 for month 02 in other years; 31 for all other months. It then restarts at 01 and the month advances.
- R5: Month 12 wraps to 01 and advances the year (0x06). Year 99 wraps to 00.
- R6: A write to address 0x00 clears the prescaler. The next second increment occurs only after a further TICKS_PER_SEC `subTick` pulses.
- R7: Writes keep only the valid bits of each field: mask 0x7F for seconds and minutes, 0x3F for hours and date, 0x07 for weekday, 0x1F for month, and all 8 bits for year. Alarm minute (0x07) keeps 0x7F; alarm hour (0x08) and alarm date (0x09) keep 0x3F. Unmapped addresses read 0x00 and ignore writes.
- R8: When the seconds roll from 59 to 00 and the new minute, hour and date equal 0x07, 0x08 and 0x09, status bit 2 (alarm flag) is set, whether or not its enable is on. A mismatch in any field leaves the flag clear.
- R9: Status bit 4 (update flag) is set on every second increment.
- R10: Status bits 0 (power-on flag, set by reset), 2 and 4 are sticky. Writing a 0 to a bit clears that flag; writing a 1 leaves it unchanged. All other status bits read 0.
- R11: `irqN` is 0 exactly while (status bit 2 and enable bit 3) or (status bit 4 and enable bit 5) hold.
- R12: The enable register at 0x10 stores and reads back all 8 bits written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| subTick | input | 1 | Prescaler step strobe, one clock wide per pulse |
| wrEn | input | 1 | Write strobe for `addr`/`wrData` |
| addr | input | 8 | Register address for both read and write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data at `addr` |
| irqN | output | 1 | Active-low level interrupt |

## Verification
The range assertions assume that every written time field is valid BCD within its range. For that reason they only check the value after an increment from a value that is already in range. The prescaler assertion assumes TICKS_PER_SEC is at least two. The stimulus only writes legal BCD, including the masked writes, which use upper bits the mask removes while the kept bits remain in range. It never issues a write and a `subTick` pulse in the same cycle. The calendar vectors each load a full date and check the state one second later, covering every month-length case and every carry depth.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 8;

  typedef logic [REG_W-1:0]  reg_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // address map; time fields must stay contiguous from 0x00
  localparam addr_t A_SEC   = 8'h00;
  localparam addr_t A_MIN   = 8'h01;
  localparam addr_t A_HOUR  = 8'h02;
  localparam addr_t A_WDAY  = 8'h03;
  localparam addr_t A_DATE  = 8'h04;
  localparam addr_t A_MON   = 8'h05;
  localparam addr_t A_YEAR  = 8'h06;
  localparam addr_t A_AMIN  = 8'h07;
  localparam addr_t A_AHOUR = 8'h08;
  localparam addr_t A_ADATE = 8'h09;
  localparam addr_t A_STAT  = 8'h0E;
  localparam addr_t A_CTRL  = 8'h10;

  // write masks
  localparam reg_t M_MINSEC = 8'h7F;
  localparam reg_t M_HRDATE = 8'h3F;
  localparam reg_t M_WDAY   = 8'h07;
  localparam reg_t M_MON    = 8'h1F;

  // status and enable bit positions
  localparam int ST_POR = 0;
  localparam int ST_ALM = 2;
  localparam int ST_UPD = 4;
  localparam int EN_ALM = 3;
  localparam int EN_UPD = 5;

  // strobes from control to calendar datapath
  typedef struct packed {
    logic  secTick;
    logic  wrValid;
    addr_t addr;
    reg_t  data;
  } ctlStrobe_t;
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       subTick,
  input  logic       wrEn,
  input  addr_t      wrAddr,
  input  reg_t       wrData,
  input  logic       alarmHit,
  output ctlStrobe_t stb,
  output reg_t       statusByte,
  output reg_t       ctrlByte,
  output logic       irqN
);
  localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_PER_SEC - 1);

  logic [CNT_W-1:0] preCnt;
  logic wrSec, wrStat, wrCtrl, secTick;
  logic porF, almF, updF;
  reg_t ctrlR;

  assign wrSec  = wrEn && (wrAddr == A_SEC);
  assign wrStat = wrEn && (wrAddr == A_STAT);
  assign wrCtrl = wrEn && (wrAddr == A_CTRL);
  assign secTick = subTick && (preCnt == CNT_LAST) && !wrSec;

  always_ff @(posedge clk) begin
    if (!rstN)             preCnt <= '0;
    else if (wrSec)        preCnt <= '0;
    else if (subTick)      preCnt <= (preCnt == CNT_LAST) ? '0 : preCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      porF  <= 1'b1;
      almF  <= 1'b0;
      updF  <= 1'b0;
      ctrlR <= '0;
    end else begin
      porF <= wrStat ? (porF & wrData[ST_POR]) : porF;
      almF <= (wrStat ? (almF & wrData[ST_ALM]) : almF) | alarmHit;
      updF <= (wrStat ? (updF & wrData[ST_UPD]) : updF) | secTick;
      if (wrCtrl) ctrlR <= wrData;
    end
  end

  always_comb begin
    statusByte         = '0;
    statusByte[ST_POR] = porF;
    statusByte[ST_ALM] = almF;
    statusByte[ST_UPD] = updF;
  end

  assign ctrlByte = ctrlR;
  assign irqN = !((almF && ctrlR[EN_ALM]) || (updF && ctrlR[EN_UPD]));

  assign stb.secTick = secTick;
  assign stb.wrValid = wrEn;
  assign stb.addr    = wrAddr;
  assign stb.data    = wrData;

  // R6: a seconds write restarts the prescaler, so no tick follows at once
  a_r6_prescale_restart: assert property (@(posedge clk) disable iff (!rstN)
    (wrSec && (TICKS_PER_SEC > 1)) |=> !secTick);

  // R9: every second increment leaves the update flag set
  a_r9_update_set: assert property (@(posedge clk) disable iff (!rstN)
    secTick |=> updF);

  // R10: the alarm flag holds until a status write clears it
  a_r10_alarm_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (almF && !wrStat) |=> almF);

  // R10: once cleared, the power-on flag never comes back without reset
  a_r10_por_no_reset: assert property (@(posedge clk) disable iff (!rstN)
    !porF |=> !porF);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t stb,
  input  addr_t      rdAddr,
  output reg_t       rdData,
  output logic       alarmHit
);
  reg_t secR, minR, hourR, wdayR, dateR, monR, yearR;
  reg_t almMin, almHour, almDate;

  function automatic reg_t bcdNext(input reg_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // BCD year divisible by 4: even tens with ones 0/4/8, odd tens with ones 2/6
  function automatic logic leapYear(input reg_t y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic bcdOk(input reg_t v, input reg_t lo, input reg_t hi);
    return (v[3:0] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction

  reg_t lastDay;
  always_comb begin
    case (monR)
      8'h02:                      lastDay = leapYear(yearR) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: lastDay = 8'h30;
      default:                    lastDay = 8'h31;
    endcase
  end

  logic secWrap, minWrap, hourWrap, dateWrap, monWrap;
  logic cMin, cHour, cDate, cMon;
  reg_t nSec, nMin, nHour, nWday, nDate, nMon, nYear;

  always_comb begin
    secWrap  = (secR == 8'h59);
    minWrap  = (minR == 8'h59);
    hourWrap = (hourR == 8'h23);
    dateWrap = (dateR == lastDay);
    monWrap  = (monR == 8'h12);
    cMin  = secWrap;
    cHour = cMin && minWrap;
    cDate = cHour && hourWrap;
    cMon  = cDate && dateWrap;
    nSec  = secWrap ? 8'h00 : bcdNext(secR);
    nMin  = cMin  ? (minWrap  ? 8'h00 : bcdNext(minR))  : minR;
    nHour = cHour ? (hourWrap ? 8'h00 : bcdNext(hourR)) : hourR;
    nWday = cDate ? ((wdayR == 8'd6) ? 8'd0 : wdayR + 8'd1) : wdayR;
    nDate = cDate ? (dateWrap ? 8'h01 : bcdNext(dateR)) : dateR;
    nMon  = cMon  ? (monWrap  ? 8'h01 : bcdNext(monR))  : monR;
    nYear = (cMon && monWrap) ? ((yearR == 8'h99) ? 8'h00 : bcdNext(yearR)) : yearR;
  end

  // alarm tested only when seconds roll to 00, against the new time
  assign alarmHit = stb.secTick && secWrap &&
                    (nMin == almMin) && (nHour == almHour) && (nDate == almDate);

  logic wrTime;
  assign wrTime = stb.wrValid && (stb.addr <= A_YEAR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secR <= 8'h00; minR <= 8'h00; hourR <= 8'h00; wdayR <= 8'h00;
      dateR <= 8'h01; monR <= 8'h01; yearR <= 8'h00;
    end else if (wrTime) begin
      case (stb.addr)
        A_SEC:   secR  <= stb.data & M_MINSEC;
        A_MIN:   minR  <= stb.data & M_MINSEC;
        A_HOUR:  hourR <= stb.data & M_HRDATE;
        A_WDAY:  wdayR <= stb.data & M_WDAY;
        A_DATE:  dateR <= stb.data & M_HRDATE;
        A_MON:   monR  <= stb.data & M_MON;
        default: yearR <= stb.data;
      endcase
    end else if (stb.secTick) begin
      secR <= nSec; minR <= nMin; hourR <= nHour; wdayR <= nWday;
      dateR <= nDate; monR <= nMon; yearR <= nYear;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      almMin <= '0; almHour <= '0; almDate <= '0;
    end else if (stb.wrValid) begin
      if (stb.addr == A_AMIN)  almMin  <= stb.data & M_MINSEC;
      if (stb.addr == A_AHOUR) almHour <= stb.data & M_HRDATE;
      if (stb.addr == A_ADATE) almDate <= stb.data & M_HRDATE;
    end
  end

  always_comb begin
    case (rdAddr)
      A_SEC:   rdData = secR;
      A_MIN:   rdData = minR;
      A_HOUR:  rdData = hourR;
      A_WDAY:  rdData = wdayR;
      A_DATE:  rdData = dateR;
      A_MON:   rdData = monR;
      A_YEAR:  rdData = yearR;
      A_AMIN:  rdData = almMin;
      A_AHOUR: rdData = almHour;
      A_ADATE: rdData = almDate;
      default: rdData = '0;
    endcase
  end

  // R2: seconds stay legal BCD across an increment
  a_r2_sec_bcd: assert property (@(posedge clk) disable iff (!rstN)
    (stb.secTick && !wrTime && bcdOk(secR, 8'h00, 8'h59)) |=> bcdOk(secR, 8'h00, 8'h59));

  // R3: hours stay within 00..23 across an increment
  a_r3_hour_range: assert property (@(posedge clk) disable iff (!rstN)
    (stb.secTick && !wrTime && bcdOk(hourR, 8'h00, 8'h23)) |=> bcdOk(hourR, 8'h00, 8'h23));

  // R4: date stays within 01..31 across an increment
  a_r4_date_range: assert property (@(posedge clk) disable iff (!rstN)
    (stb.secTick && !wrTime && bcdOk(dateR, 8'h01, lastDay)) |=> bcdOk(dateR, 8'h01, 8'h31));

  // R5: month stays within 01..12 across an increment
  a_r5_month_range: assert property (@(posedge clk) disable iff (!rstN)
    (stb.secTick && !wrTime && bcdOk(monR, 8'h01, 8'h12)) |=> bcdOk(monR, 8'h01, 8'h12));
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       subTick,
  input  logic       wrEn,
  input  logic [7:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       irqN
);
  ctlStrobe_t stb;
  reg_t statusByte, ctrlByte, calRd;
  logic alarmHit;

  rtc_ctrl #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_ctrl (
    .clk(clk), .rstN(rstN), .subTick(subTick), .wrEn(wrEn),
    .wrAddr(addr), .wrData(wrData), .alarmHit(alarmHit),
    .stb(stb), .statusByte(statusByte), .ctrlByte(ctrlByte), .irqN(irqN)
  );

  rtc_calendar u_cal (
    .clk(clk), .rstN(rstN), .stb(stb), .rdAddr(addr),
    .rdData(calRd), .alarmHit(alarmHit)
  );

  always_comb begin
    if (addr == A_STAT)      rdData = statusByte;
    else if (addr == A_CTRL) rdData = ctrlByte;
    else                     rdData = calRd;
  end
endmodule

// File: tb/rtc_core_tb.sv
`timescale 1ns/1ps
module rtc_core_tb;
  localparam int TPS = 4;
  localparam int NVEC = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic subTick = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic irqN;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  rtc_core #(.TICKS_PER_SEC(TPS)) u_dut (
    .clk(clk), .rstN(rstN), .subTick(subTick), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqN(irqN)
  );

  // {year,mon,date,wday,hour,min,sec} loaded, then same one second later
  localparam logic [111:0] VEC [NVEC] = '{
    {56'h00_01_01_00_00_00_00, 56'h00_01_01_00_00_00_01}, // R2 first step
    {56'h00_01_01_00_00_00_09, 56'h00_01_01_00_00_00_10}, // R2 BCD digit carry
    {56'h00_01_01_00_00_00_59, 56'h00_01_01_00_00_01_00}, // R3 minute carry
    {56'h00_01_01_00_00_59_59, 56'h00_01_01_00_01_00_00}, // R3 hour carry
    {56'h00_01_01_00_19_59_59, 56'h00_01_01_00_20_00_00}, // R3 hour BCD digit
    {56'h24_06_15_06_23_59_59, 56'h24_06_16_00_00_00_00}, // R3 day and weekday wrap
    {56'h24_02_28_01_23_59_59, 56'h24_02_29_02_00_00_00}, // R4 leap February
    {56'h23_02_28_01_23_59_59, 56'h23_03_01_02_00_00_00}, // R4 common February
    {56'h24_02_29_03_23_59_59, 56'h24_03_01_04_00_00_00}, // R4 leap day end
    {56'h10_04_30_02_23_59_59, 56'h10_05_01_03_00_00_00}, // R4 30-day month
    {56'h05_01_30_04_23_59_59, 56'h05_01_31_05_00_00_00}, // R4 31-day month
    {56'h00_02_28_05_23_59_59, 56'h00_02_29_06_00_00_00}, // R4 year 00 is leap
    {56'h99_12_31_06_23_59_59, 56'h00_01_01_00_00_00_00}, // R5 century wrap
    {56'h21_12_31_02_23_59_59, 56'h22_01_01_03_00_00_00}  // R5 year advance
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    subTick = 1'b1;
    repeat (n) @(negedge clk);
    subTick = 1'b0;
  endtask

  task automatic readTime(output logic [55:0] t);
    logic [7:0] b;
    for (int i = 6; i >= 0; i--) begin
      rd(8'(i), b);
      t[i*8 +: 8] = b;
    end
  endtask

  task automatic loadTime(input logic [55:0] t);
    for (int i = 6; i >= 0; i--) wr(8'(i), t[i*8 +: 8]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [55:0] t;
    logic [7:0] b;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readTime(t);
    chk("R1 time", 64'(t), 64'h00_01_01_00_00_00_00);
    rd(8'h0E, b); chk("R1 status", 64'(b), 64'h01);
    rd(8'h10, b); chk("R1 enables", 64'(b), 64'h00);
    chk("R1 irqN", 64'(irqN), 64'h1);

    // R2..R5 calendar vectors
    for (int v = 0; v < NVEC; v++) begin
      loadTime(VEC[v][111:56]);
      ticks(TPS);
      readTime(t);
      chk($sformatf("calendar vector %0d", v), 64'(t), 64'(VEC[v][55:0]));
    end

    // R6 seconds write restarts prescaler
    wr(8'h00, 8'h10);
    ticks(TPS - 1);
    wr(8'h00, 8'h20);
    ticks(TPS - 1);
    rd(8'h00, b); chk("R6 no early tick", 64'(b), 64'h20);
    ticks(1);
    rd(8'h00, b); chk("R6 tick after full period", 64'(b), 64'h21);

    // R7 write masks and unmapped space
    wr(8'h00, 8'hD9); rd(8'h00, b); chk("R7 sec mask", 64'(b), 64'h59);
    wr(8'h02, 8'hE3); rd(8'h02, b); chk("R7 hour mask", 64'(b), 64'h23);
    wr(8'h03, 8'hF5); rd(8'h03, b); chk("R7 weekday mask", 64'(b), 64'h05);
    wr(8'h05, 8'hF2); rd(8'h05, b); chk("R7 month mask", 64'(b), 64'h12);
    wr(8'h08, 8'hD1); rd(8'h08, b); chk("R7 alarm hour mask", 64'(b), 64'h11);
    wr(8'h0A, 8'h55); rd(8'h0A, b); chk("R7 unmapped write", 64'(b), 64'h00);
    rd(8'h0F, b); chk("R7 unmapped read", 64'(b), 64'h00);

    // R10 power-on flag: 1 keeps it, 0 clears it
    wr(8'h0E, 8'hFF); rd(8'h0E, b); chk("R10 write ones keeps", 64'(b), 64'h11);
    wr(8'h0E, 8'h00); rd(8'h0E, b); chk("R10 clear all", 64'(b), 64'h00);

    // R8 alarm match at minute boundary, enable off
    loadTime(56'h21_03_05_00_10_29_58);
    wr(8'h07, 8'h30); wr(8'h08, 8'h10); wr(8'h09, 8'h05);
    ticks(TPS);
    rd(8'h0E, b); chk("R9 update flag, R8 no early alarm", 64'(b), 64'h10);
    ticks(TPS);
    rd(8'h0E, b); chk("R8 alarm flag set", 64'(b), 64'h14);
    chk("R11 irqN high with enables off", 64'(irqN), 64'h1);
    wr(8'h10, 8'h08);
    #1 chk("R11 irqN low on alarm enable", 64'(irqN), 64'h0);
    wr(8'h0E, 8'hFF); rd(8'h0E, b); chk("R10 ones leave flags", 64'(b), 64'h14);
    wr(8'h0E, 8'hFB); rd(8'h0E, b); chk("R10 clear alarm only", 64'(b), 64'h10);
    chk("R11 irqN released", 64'(irqN), 64'h1);
    wr(8'h10, 8'h20);
    #1 chk("R11 irqN low on update enable", 64'(irqN), 64'h0);
    wr(8'h0E, 8'h00);
    #1 chk("R11 irqN released after clear", 64'(irqN), 64'h1);

    // R8 mismatch on hour: no alarm flag
    wr(8'h10, 8'h00);
    loadTime(56'h21_03_05_00_10_30_59);
    wr(8'h07, 8'h31); wr(8'h08, 8'h11); wr(8'h09, 8'h05);
    ticks(TPS);
    rd(8'h0E, b); chk("R8 hour mismatch no alarm", 64'(b), 64'h10);

    // R12 enable register read-back
    wr(8'h10, 8'hA5); rd(8'h10, b); chk("R12 enable readback", 64'(b), 64'hA5);
    wr(8'h10, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule